// File: doc/BRIEF.md
# Transmit Queue Frame Write Logic

This block takes one outgoing frame from a host bus and hands it to a transmit queue as a series of 32-bit word writes. The host first writes a control word. That word opens a new frame and carries an 8-bit frame ID and 4 bits of transmit options. The host then programs the frame length in bytes and streams the data words. It may send them in one burst or in several bursts with idle cycles between them.

The block counts down the bytes still owed. It pushes each accepted word into the queue write port with its byte-lane enables. It works out which lanes of the final word are valid from the programmed length. It flags the final word as end of frame and then returns to idle. Two single-cycle event pulses go to the interrupt logic:
- An under-run pulse when a new control word arrives before the current frame has completed. The old frame is aborted.
- An overrun pulse when a data word arrives that has no room left in the frame. That word is dropped.

The controller has three states:
- `ST_IDLE`: no frame is open.
- `ST_ARMED`: the control word has been taken and a valid length is awaited.
- `ST_FILL`: data words are being counted.

It has these transitions:
- `ST_IDLE`/`ST_FILL` → `ST_ARMED` on a control write. From `ST_ARMED` or `ST_FILL` this also raises under-run.
- `ST_ARMED` → `ST_ARMED` on another control write (with under-run) or on a zero-length write (ignored).
- `ST_ARMED` → `ST_FILL` on a nonzero length write.
- `ST_FILL` → `ST_FILL` on a non-final data word.
- `ST_FILL` → `ST_IDLE` on the final data word.
- A data write in `ST_IDLE` or `ST_ARMED` stays put and raises overrun.

Top module: `txq_frame_writer`

## Requirements
- R1: After reset, `q_push`, `q_eof`, `underrun_pulse` and `overrun_pulse` are all 0, and a first data write raises overrun (no frame is open).
- R2: A control write latches `ctl_id` and `ctl_opt`. Every word pushed for that frame shows those values on `q_id` and `q_opt`.
- R3: A control write while a frame is armed or filling gives `underrun_pulse`=1 in the cycle after the write edge, for exactly one cycle per such write. A control write from idle gives no pulse.
- R4: Each accepted data word appears on `q_word` with `q_push`=1 one cycle after its write edge. Every word except the final one has `q_be`=4'b1111 and `q_eof`=0.
- R5: Byte lanes are little-endian; lane k is `q_be[k]`. The final word has `q_eof`=1 and `q_be`=(1<<r)-1, where r = length mod 4. When r=0 the final word has `q_be`=4'b1111.
- R6: A data write after the final word of a frame has `q_push`=0 and `overrun_pulse`=1 one cycle later, and the word is not pushed.
- R7: A length write of 0 is ignored and the frame stays armed. Data writes in that state raise overrun without a push. A later nonzero length write still arms the frame.
- R8: The byte position is held across idle gaps of any length between data writes of one frame.
- R9: Priority within a cycle is control write, then length write, then data write. A lower-priority write in the same cycle is ignored: no push and no overrun for it.
- R10: After the final word the block is idle, so the next control write raises no under-run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control-word write strobe (opens a frame) |
| ctl_id | input | 8 | Frame ID carried by the control write |
| ctl_opt | input | 4 | Transmit options carried by the control write |
| len_wr | input | 1 | Frame-length write strobe |
| len_bytes | input | 16 | Frame length in bytes |
| data_wr | input | 1 | Data-word write strobe |
| data_word | input | 32 | Data word |
| q_push | output | 1 | Queue write-port push |
| q_word | output | 32 | Word pushed to the queue |
| q_be | output | 4 | Valid byte lanes of the pushed word |
| q_eof | output | 1 | Pushed word is the last of the frame |
| q_id | output | 8 | Frame ID of the current frame |
| q_opt | output | 4 | Transmit options of the current frame |
| underrun_pulse | output | 1 | One-cycle under-run (abort) event |
| overrun_pulse | output | 1 | One-cycle overrun event |

## Verification
A wrong remaining-byte count shows at the ports on the final word of the frame. It shows as a lane mask that disagrees with the length modulo four, as end of frame raised one word early or late, or as a spurious overrun on the next write. All of these are visible one cycle after the offending write edge. A wrong controller state shows as an under-run where none should be, or none where one should be, one cycle after a control write. It can also show as a push where overrun was due, so each length/remainder combination is checked word by word, along with one extra write per frame.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FILL  = 2'd2
    } txq_state_e;
endpackage

// File: rtl/txq_byte_count.sv
module txq_byte_count #(
    parameter int SIZE_W = 16,
    parameter int BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SIZE_W-1:0] load_val,
    input  logic              consume,
    output logic [SIZE_W-1:0] remaining,
    output logic              is_last
);
    localparam logic [SIZE_W-1:0] STEP = SIZE_W'(BYTES);

    logic [SIZE_W-1:0] rem_q;

    assign remaining = rem_q;
    assign is_last   = (rem_q != '0) && (rem_q <= STEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (consume) begin
            rem_q <= is_last ? '0 : rem_q - STEP;
        end
    end

    // R8: a loaded length is held exactly until words consume it
    p_load_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> remaining == $past(load_val));
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !consume) |=> $stable(remaining));
endmodule

// File: rtl/txq_lane_mask.sv
module txq_lane_mask #(
    parameter int SIZE_W = 16,
    parameter int BYTES  = 4
) (
    input  logic [SIZE_W-1:0] remaining,
    input  logic              is_last,
    output logic [BYTES-1:0]  be
);
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign be[i] = !is_last || (remaining > SIZE_W'(i));
    end
endmodule

// File: rtl/txq_frame_writer.sv
module txq_frame_writer #(
    parameter int DATA_W = 32,
    parameter int SIZE_W = 16,
    parameter int ID_W   = 8,
    parameter int OPT_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic [ID_W-1:0]     ctl_id,
    input  logic [OPT_W-1:0]    ctl_opt,
    input  logic                len_wr,
    input  logic [SIZE_W-1:0]   len_bytes,
    input  logic                data_wr,
    input  logic [DATA_W-1:0]   data_word,
    output logic                q_push,
    output logic [DATA_W-1:0]   q_word,
    output logic [DATA_W/8-1:0] q_be,
    output logic                q_eof,
    output logic [ID_W-1:0]     q_id,
    output logic [OPT_W-1:0]    q_opt,
    output logic                underrun_pulse,
    output logic                overrun_pulse
);
    import txq_pkg::*;

    localparam int BYTES = DATA_W / 8;
    localparam logic [BYTES-1:0] ALL_LANES = '1;

    txq_state_e        state_q, state_d;
    logic              load, consume, latch_hdr;
    logic              push_d, eof_d, under_d, over_d;
    logic [SIZE_W-1:0] remaining;
    logic              is_last;
    logic [BYTES-1:0]  lane_be;

    txq_byte_count #(.SIZE_W(SIZE_W), .BYTES(BYTES)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_val  (len_bytes),
        .consume   (consume),
        .remaining (remaining),
        .is_last   (is_last)
    );

    txq_lane_mask #(.SIZE_W(SIZE_W), .BYTES(BYTES)) u_mask (
        .remaining (remaining),
        .is_last   (is_last),
        .be        (lane_be)
    );

    // Next-state and event decode: control > length > data
    always_comb begin
        state_d   = state_q;
        load      = 1'b0;
        consume   = 1'b0;
        latch_hdr = 1'b0;
        push_d    = 1'b0;
        eof_d     = 1'b0;
        under_d   = 1'b0;
        over_d    = 1'b0;
        if (ctl_wr) begin
            under_d   = (state_q != ST_IDLE);
            latch_hdr = 1'b1;
            state_d   = ST_ARMED;
        end else if (len_wr) begin
            if (state_q == ST_ARMED && len_bytes != '0) begin
                load    = 1'b1;
                state_d = ST_FILL;
            end
        end else if (data_wr) begin
            unique case (state_q)
                ST_FILL: begin
                    consume = 1'b1;
                    push_d  = 1'b1;
                    eof_d   = is_last;
                    if (is_last) state_d = ST_IDLE;
                end
                ST_IDLE, ST_ARMED: over_d = 1'b1;
                default: over_d = 1'b1;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_push         <= 1'b0;
            q_word         <= '0;
            q_be           <= '0;
            q_eof          <= 1'b0;
            q_id           <= '0;
            q_opt          <= '0;
            underrun_pulse <= 1'b0;
            overrun_pulse  <= 1'b0;
        end else begin
            q_push         <= push_d;
            q_eof          <= eof_d;
            underrun_pulse <= under_d;
            overrun_pulse  <= over_d;
            if (push_d) begin
                q_word <= data_word;
                q_be   <= lane_be;
            end
            if (latch_hdr) begin
                q_id  <= ctl_id;
                q_opt <= ctl_opt;
            end
        end
    end

    p_underrun_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_pulse |-> ($past(ctl_wr) && $past(state_q) != ST_IDLE));
    p_eof_with_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q_eof |-> q_push);
    p_lanes_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |-> (q_be != '0 && ((q_be & (q_be + 1'b1)) == '0)));
    p_full_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q_push && !q_eof) |-> q_be == ALL_LANES);
    p_overrun_nopush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_pulse |-> !q_push);
    p_fill_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> remaining != '0);
    p_ctl_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (!q_push && !overrun_pulse));
    p_eof_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q_eof |-> state_q == ST_IDLE);
endmodule

// File: tb/sim_txq_frame_writer.sv
module sim_txq_frame_writer;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    // {length[15:0], expected final-word lanes[3:0]}
    localparam logic [19:0] VEC [NV] = '{
        {16'd1,  4'b0001}, {16'd2,  4'b0011}, {16'd3,  4'b0111}, {16'd4,  4'b1111},
        {16'd5,  4'b0001}, {16'd8,  4'b1111}, {16'd11, 4'b0111}, {16'd14, 4'b0011}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0, len_wr = 1'b0, data_wr = 1'b0;
    logic [7:0]  ctl_id = '0;
    logic [3:0]  ctl_opt = '0;
    logic [15:0] len_bytes = '0;
    logic [31:0] data_word = '0;
    logic        q_push, q_eof, underrun_pulse, overrun_pulse;
    logic [31:0] q_word;
    logic [3:0]  q_be, q_opt;
    logic [7:0]  q_id;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txq_frame_writer u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_id(ctl_id), .ctl_opt(ctl_opt),
        .len_wr(len_wr), .len_bytes(len_bytes), .data_wr(data_wr), .data_word(data_word),
        .q_push(q_push), .q_word(q_word), .q_be(q_be), .q_eof(q_eof), .q_id(q_id),
        .q_opt(q_opt), .underrun_pulse(underrun_pulse), .overrun_pulse(overrun_pulse)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic op(input logic c, input logic s, input logic d, input logic [7:0] id,
                      input logic [3:0] opt, input logic [15:0] sz, input logic [31:0] w);
        @(negedge clk);
        ctl_wr = c; len_wr = s; data_wr = d;
        ctl_id = id; ctl_opt = opt; len_bytes = sz; data_word = w;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) op(1'b0, 1'b0, 1'b0, 8'h0, 4'h0, 16'h0, 32'h0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!q_push && !q_eof && !underrun_pulse && !overrun_pulse, "R1 reset outputs",
            {q_push, q_eof, underrun_pulse, overrun_pulse}, 0);
        @(negedge clk); rst_n = 1'b1;
        op(1'b0, 1'b0, 1'b1, 8'h0, 4'h0, 16'h0, 32'hDEAD);
        chk(overrun_pulse && !q_push, "R1 data with no frame", {q_push, overrun_pulse}, 2'b01);
        idle(1);

        // Table walk: one frame per vector, then one extra word
        for (int i = 0; i < NV; i++) begin
            logic [15:0] sz;
            logic [3:0]  lastbe;
            int          nw;
            sz = VEC[i][19:4];
            lastbe = VEC[i][3:0];
            nw = (int'(sz) + 3) / 4;
            op(1'b1, 1'b0, 1'b0, 8'(i + 8'h40), 4'(i), 16'h0, 32'h0);
            chk(!underrun_pulse, "R10 control from idle no underrun", underrun_pulse, 0);
            op(1'b0, 1'b1, 1'b0, 8'h0, 4'h0, sz, 32'h0);
            chk(!q_push && !overrun_pulse, "R4 length write no push", {q_push, overrun_pulse}, 0);
            for (int k = 0; k < nw; k++) begin
                logic [31:0] w;
                bit          last;
                w = {8'(i), 8'(k), 16'hA5C3};
                last = (k == nw - 1);
                op(1'b0, 1'b0, 1'b1, 8'h0, 4'h0, 16'h0, w);
                chk(q_push && q_word == w, "R4 word pushed", {q_push, q_word}, {1'b1, w});
                chk(q_id == 8'(i + 8'h40) && q_opt == 4'(i), "R2 id/opt", {q_id, q_opt},
                    {8'(i + 8'h40), 4'(i)});
                if (last) begin
                    chk(q_eof && q_be == lastbe, "R5 final lanes and eof", {q_eof, q_be}, {1'b1, lastbe});
                end else begin
                    chk(!q_eof && q_be == 4'hF, "R4 full lanes", {q_eof, q_be}, {1'b0, 4'hF});
                end
            end
            op(1'b0, 1'b0, 1'b1, 8'h0, 4'h0, 16'h0, 32'hBAD0);
            chk(overrun_pulse && !q_push, "R6 extra word overrun", {q_push, overrun_pulse}, 2'b01);
            idle(1);
            chk(!overrun_pulse, "R6 overrun single cycle", overrun_pulse, 0);
        end

        // R3: abort mid-fill
        op(1'b1, 1'b0, 1'b0, 8'h11, 4'h1, 16'h0, 32'h0);
        op(1'b0, 1'b1, 1'b0, 8'h0, 4'h0, 16'd12, 32'h0);
        op(1'b0, 1'b0, 1'b1, 8'h0, 4'h0, 16'h0, 32'h1);
        op(1'b1, 1'b0, 1'b0, 8'h22, 4'h2, 16'h0, 32'h0);
        chk(underrun_pulse && !q_push, "R3 underrun from fill", {underrun_pulse, q_push}, 2'b10);
        idle(1);
        chk(!underrun_pulse, "R3 underrun single cycle", underrun_pulse, 0);
        op(1'b0, 1'b1, 1'b0, 8'h0, 4'h0, 16'd4, 32'h0);
        op(1'b0, 1'b0, 1'b1, 8'h0, 4'h0, 16'h0, 32'h2222);
        chk(q_push && q_eof && q_be == 4'hF && q_id == 8'h22 && q_opt == 4'h2,
            "R2 new frame after abort", {q_eof, q_be, q_id, q_opt}, {1'b1, 4'hF, 8'h22, 4'h2});

        // R3: abort while armed
        op(1'b1, 1'b0, 1'b0, 8'h33, 4'h3, 16'h0, 32'h0);
        chk(!underrun_pulse, "R10 no underrun after eof", underrun_pulse, 0);
        op(1'b1, 1'b0, 1'b0, 8'h34, 4'h4, 16'h0, 32'h0);
        chk(underrun_pulse, "R3 underrun from armed", underrun_pulse, 1);

        // R7: zero length
        op(1'b0, 1'b1, 1'b0, 8'h0, 4'h0, 16'd0, 32'h0);
        op(1'b0, 1'b0, 1'b1, 8'h0, 4'h0, 16'h0, 32'h7);
        chk(overrun_pulse && !q_push, "R7 zero length overrun", {q_push, overrun_pulse}, 2'b01);
        op(1'b0, 1'b1, 1'b0, 8'h0, 4'h0, 16'd3, 32'h0);
        op(1'b0, 1'b0, 1'b1, 8'h0, 4'h0, 16'h0, 32'h8);
        chk(q_push && q_eof && q_be == 4'h7, "R7 rearm after zero", {q_push, q_eof, q_be}, {2'b11, 4'h7});

        // R8: bursts with gaps
        op(1'b1, 1'b0, 1'b0, 8'h55, 4'h5, 16'h0, 32'h0);
        op(1'b0, 1'b1, 1'b0, 8'h0, 4'h0, 16'd10, 32'h0);
        op(1'b0, 1'b0, 1'b1, 8'h0, 4'h0, 16'h0, 32'h10);
        idle(5);
        op(1'b0, 1'b0, 1'b1, 8'h0, 4'h0, 16'h0, 32'h11);
        chk(q_push && !q_eof && q_be == 4'hF, "R8 middle word after gap", {q_push, q_eof, q_be}, {2'b10, 4'hF});
        idle(3);
        op(1'b0, 1'b0, 1'b1, 8'h0, 4'h0, 16'h0, 32'h12);
        chk(q_push && q_eof && q_be == 4'h3, "R8 final word after gaps", {q_push, q_eof, q_be}, {2'b11, 4'h3});

        // R9: priority
        op(1'b1, 1'b0, 1'b0, 8'h66, 4'h6, 16'h0, 32'h0);
        op(1'b0, 1'b1, 1'b0, 8'h0, 4'h0, 16'd8, 32'h0);
        op(1'b0, 1'b0, 1'b1, 8'h0, 4'h0, 16'h0, 32'h20);
        op(1'b1, 1'b0, 1'b1, 8'h77, 4'h7, 16'h0, 32'h21);
        chk(underrun_pulse && !q_push && !overrun_pulse, "R9 control beats data",
            {underrun_pulse, q_push, overrun_pulse}, 3'b100);
        op(1'b0, 1'b1, 1'b1, 8'h0, 4'h0, 16'd6, 32'h22);
        chk(!q_push && !overrun_pulse, "R9 length beats data", {q_push, overrun_pulse}, 0);
        op(1'b0, 1'b0, 1'b1, 8'h0, 4'h0, 16'h0, 32'h23);
        chk(q_push && !q_eof && q_be == 4'hF && q_id == 8'h77, "R9 length taken word1",
            {q_eof, q_be, q_id}, {1'b0, 4'hF, 8'h77});
        op(1'b0, 1'b0, 1'b1, 8'h0, 4'h0, 16'h0, 32'h24);
        chk(q_push && q_eof && q_be == 4'h3, "R9 length taken final", {q_eof, q_be}, {1'b1, 4'h3});
        idle(2);
        finish_run();
    end
endmodule